// File: doc/BRIEF.md
# Sampling Converter Serial Result Port

This block is the digital side of a sampling converter that a host reads over a three-wire serial link. It repeats a fixed cycle of three phases: it converts, it sleeps, and it shifts out one result. A conversion runs for a set number of system clock cycles. At the end of it, the block takes the result from a stub that stands in for the converter core: a sign, an extended-range flag, a 24-bit code and four sub-LSB bits. It packs these into a 32-bit frame held in a shift register. There are no configuration registers. The whole cycle is steered by the active-low select and the host's serial clock.

The host pulls select low to see a live end-of-conversion flag on the data line. The flag reads 1 while a conversion runs and falls as soon as a result is ready. The host then clocks the frame out. Data moves on each falling serial clock edge, so the host can sample on the rising edge. The block starts a new conversion when the 32nd falling edge arrives, or when select goes high partway through a frame. Each frame carries the result of the conversion just before it.

Select and serial clock come from outside the system clock domain. Each passes through a synchroniser, and edges are found on the synchronised levels.

Top module: `dsc_serial_port`

## Requirements
- R1: After reset the block is converting. `res_take` pulses for exactly one cycle, CONV_CYCLES-1 cycles after reset is released. The block is in sleep on the next cycle. Exactly one of `st_convert`, `st_sleep` and `st_shift` is high at all times.
- R2: With select high, the block stays in sleep for any length of time. Serial clock edges in that time leave the held frame unchanged.
- R3: While select is high, `sdo_oe` is 0 and `sdo` is 0, which stands for the high-impedance line.
- R4: During a conversion with select low, `sdo` is 1, the end-of-conversion flag. It falls to 0 on the cycle after `res_take`, with no serial clock needed.
- R5: The frame has 32 bits and is sent MSB first. Bit 31 is the end-of-conversion flag (0 for a ready result). Bit 30 is always 0. Bit 29 is the sign (1 for a positive input). Bit 28 is the extended-range flag. Bits 27..4 are the 24-bit code, MSB first. Bits 3..0 are the sub-LSB bits.
- R6: `sdo` changes only after a falling serial clock edge. Bit 30 appears after the first falling edge and bit 0 after the 31st.
- R7: The 32nd falling edge ends the frame. The block then converts again, and `sdo` returns to 1 as the end-of-conversion flag of the next cycle.
- R8: If select goes high during data output, the transfer stops and a new conversion starts. The next frame carries the stub's value at the end of that new conversion.
- R9: If select stays low across frames, the cycle repeats without a pause. Each frame carries the result sampled at the end of the conversion just before it, with no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low select from the host, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| res_sign | input | 1 | Result sign from the stub, 1 for a positive input |
| res_ovr | input | 1 | Result extended-range flag from the stub |
| res_code | input | DATA_W | Result code from the stub |
| res_sub | input | SUB_W | Sub-LSB bits from the stub |
| res_take | output | 1 | One-cycle strobe: the stub's result is captured on this cycle |
| sdo | output | 1 | Serial data, 0 when not enabled |
| sdo_oe | output | 1 | Output enable of the serial data line |
| st_convert | output | 1 | The block is converting |
| st_sleep | output | 1 | A result is held and the block is idle |
| st_shift | output | 1 | A frame is being shifted out |

## Verification
A change on `sel_n` or `sclk` takes two synchroniser flops, and then one more register stage, to reach `sdo`, the shift register or the phase. The effect is therefore due after the third rising clock edge following the change. The bench holds each serial clock level for six system cycles. It samples at falling clock edges at least four cycles after each select or clock change, so every bit it reads has settled and has not yet been replaced. The `res_take` strobe is timed exactly: the bench counts falling clock edges from the release of reset and expects the strobe on count CONV_CYCLES-1. It expects `st_sleep` on the following cycle.

// File: rtl/dsc_port_pkg.sv
package dsc_port_pkg;

   // Status field width at the head of every frame: flag, dummy, sign, range
   localparam int STAT_W = 4;

   typedef enum logic [1:0] {
      PH_CONVERT = 2'd0,
      PH_SLEEP   = 2'd1,
      PH_SHIFT   = 2'd2
   } phase_t;

endpackage

// File: rtl/dsc_level_sync.sv
module dsc_level_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic lvl_o,
   output logic prev_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dsc_level_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RST_VAL;
               else        chain_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= RST_VAL;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign lvl_o  = chain_q[STAGES-1];
   assign prev_o = prev_q;
endmodule

// File: rtl/dsc_conv_timer.sv
module dsc_conv_timer #(
   parameter int CONV_CYCLES = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);
   generate
      if (CONV_CYCLES < 2) begin : g_bad_len
         $error("dsc_conv_timer: CONV_CYCLES must be at least 2");
      end
   endgenerate

   localparam int CNT_W = $clog2(CONV_CYCLES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   assign done_o = run_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run_i || done_o) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   // R1: the done strobe never lasts more than one cycle while running
   a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

// File: rtl/dsc_frame_shifter.sv
module dsc_frame_shifter #(
   parameter int FRAME_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic               shift_i,
   output logic               msb_o,
   output logic               last_o
);
   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("dsc_frame_shifter: FRAME_W must be at least 2");
      end
   endgenerate

   localparam int BC_W = $clog2(FRAME_W);
   localparam logic [BC_W-1:0] BC_LAST = BC_W'(FRAME_W - 1);

   logic [FRAME_W-1:0] sr_q;
   logic [BC_W-1:0]    bc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
         bc_q <= '0;
      end else if (load_i) begin
         sr_q <= frame_i;
         bc_q <= '0;
      end else if (shift_i) begin
         sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
         bc_q <= bc_q + 1'b1;
      end
   end

   assign msb_o  = sr_q[FRAME_W-1];
   assign last_o = (bc_q == BC_LAST);

   // R6: the held frame moves only on a load or a qualified shift
   a_r6_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !shift_i) |=> $stable(sr_q));
endmodule

// File: rtl/dsc_serial_port.sv
module dsc_serial_port
   import dsc_port_pkg::*;
#(
   parameter int DATA_W      = 24,
   parameter int SUB_W       = 4,
   parameter int CONV_CYCLES = 48,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              sclk,
   input  logic              res_sign,
   input  logic              res_ovr,
   input  logic [DATA_W-1:0] res_code,
   input  logic [SUB_W-1:0]  res_sub,
   output logic              res_take,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              st_convert,
   output logic              st_sleep,
   output logic              st_shift
);
   localparam int FRAME_W = STAT_W + DATA_W + SUB_W;

   generate
      if (DATA_W < 1 || SUB_W < 1) begin : g_bad_widths
         $error("dsc_serial_port: DATA_W and SUB_W must be at least 1");
      end
   endgenerate

   logic sel_lvl, sel_prev, sck_lvl, sck_prev;
   logic sck_fall;
   logic conv_done, shift_en, frame_last, frame_msb;
   logic [FRAME_W-1:0] frame_w;
   phase_t ph_q, ph_d;

   dsc_level_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
      .clk(clk), .rst_n(rst_n), .async_i(sel_n), .lvl_o(sel_lvl), .prev_o(sel_prev));

   dsc_level_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
      .clk(clk), .rst_n(rst_n), .async_i(sclk), .lvl_o(sck_lvl), .prev_o(sck_prev));

   assign sck_fall = sck_prev && !sck_lvl;

   dsc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .run_i(ph_q == PH_CONVERT), .done_o(conv_done));

   // Ready frame: flag low, dummy low, sign, range, code, sub-LSBs
   assign frame_w = {1'b0, 1'b0, res_sign, res_ovr, res_code, res_sub};

   assign shift_en = (ph_q == PH_SHIFT) && !sel_lvl && sck_fall;

   dsc_frame_shifter #(.FRAME_W(FRAME_W)) u_shifter (
      .clk(clk), .rst_n(rst_n), .load_i(conv_done), .frame_i(frame_w),
      .shift_i(shift_en), .msb_o(frame_msb), .last_o(frame_last));

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_CONVERT: if (conv_done) ph_d = PH_SLEEP;
         PH_SLEEP:   if (!sel_lvl) ph_d = PH_SHIFT;
         PH_SHIFT: begin
            if (sel_lvl)                    ph_d = PH_CONVERT;
            else if (shift_en && frame_last) ph_d = PH_CONVERT;
         end
         default:    ph_d = PH_CONVERT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_CONVERT;
      else        ph_q <= ph_d;
   end

   assign res_take   = conv_done;
   assign sdo_oe     = !sel_lvl;
   assign sdo        = sdo_oe && ((ph_q == PH_CONVERT) ? 1'b1 : frame_msb);
   assign st_convert = (ph_q == PH_CONVERT);
   assign st_sleep   = (ph_q == PH_SLEEP);
   assign st_shift   = (ph_q == PH_SHIFT);

   // R1: exactly one phase indicator is active
   a_r1_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({st_convert, st_sleep, st_shift}) == 1);

   // R1: capturing a result moves the block to sleep
   a_r1_take_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      res_take |=> st_sleep);

   // R2: sleep persists while select stays high
   a_r2_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st_sleep && sel_lvl) |=> st_sleep);

   // R4: the flag drops right after capture when the line is enabled
   a_r4_flag_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (res_take && !sel_lvl && !sel_prev) |=> (sdo_oe -> !sdo));

   // R7: the last falling edge restarts conversion
   a_r7_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && frame_last) |=> st_convert);

   // R8: deselect during output aborts to conversion
   a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (st_shift && sel_lvl) |=> st_convert);
endmodule

// File: tb/dsc_serial_port_bench.sv
module dsc_serial_port_bench;
   localparam int CONV = 40;
   localparam int HALF = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_n = 1'b1;
   logic sclk = 1'b0;
   logic r_sign = 1'b0;
   logic r_ovr = 1'b0;
   logic [23:0] r_code = '0;
   logic [3:0]  r_sub = '0;
   logic res_take, sdo, sdo_oe, st_convert, st_sleep, st_shift;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   typedef struct { logic val; string tag; int idx; } item_t;
   item_t exp_q[$];
   event smp;

   always #4 clk = ~clk;

   dsc_serial_port #(.DATA_W(24), .SUB_W(4), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) u_dsc_serial_port (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk),
      .res_sign(r_sign), .res_ovr(r_ovr), .res_code(r_code), .res_sub(r_sub),
      .res_take(res_take), .sdo(sdo), .sdo_oe(sdo_oe),
      .st_convert(st_convert), .st_sleep(st_sleep), .st_shift(st_shift));

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Driver side: expected bits of a frame, MSB first, first nb bits
   task automatic push_frame(input logic s, input logic o, input logic [23:0] c,
                             input logic [3:0] u, input int nb, input string tag);
      logic [31:0] f;
      f = {1'b0, 1'b0, s, o, c, u};
      for (int k = 0; k < nb; k++) begin
         item_t it;
         it.val = f[31-k];
         it.tag = tag;
         it.idx = 31 - k;
         exp_q.push_back(it);
      end
   endtask

   // Monitor: pops one expected bit per sample request
   always @(smp) begin
      item_t it;
      if (exp_q.size() == 0) begin
         chk(1'b0, "R5 queue underrun", 32'(sdo), 32'hx);
      end else begin
         it = exp_q.pop_front();
         chk(sdo_oe === 1'b1 && sdo === it.val,
             $sformatf("%s frame bit %0d", it.tag, it.idx), 32'(sdo), 32'(it.val));
      end
   end

   task automatic pulse_sclk();
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   // Samples nb bits, with nb-1 falling edges between them
   task automatic read_bits(input int nb);
      ->smp;
      #1;
      for (int k = 1; k < nb; k++) begin
         pulse_sclk();
         ->smp;
         #1;
      end
   endtask

   task automatic wait_sleep();
      for (int k = 0; k < 4 * CONV && !st_sleep; k++) @(negedge clk);
   endtask

   task automatic set_result(input logic s, input logic o, input logic [23:0] c, input logic [3:0] u);
      r_sign = s; r_ovr = o; r_code = c; r_sub = u;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stimulus
      int n;
      set_result(1'b1, 1'b0, 24'hA5C30F, 4'h9);
      repeat (5) @(negedge clk);
      // R1: reset state
      chk(st_convert && !st_sleep && !st_shift, "R1 reset phase", {st_convert, st_sleep, st_shift}, 3'b100);
      chk(!sdo_oe && !sdo, "R3 reset line quiet", {sdo_oe, sdo}, 0);
      chk(!res_take, "R1 no strobe in reset", res_take, 0);

      rst_n = 1'b1;
      n = 0;
      while (n < 1000) begin
         @(negedge clk);
         n++;
         if (res_take) break;
      end
      chk(n == CONV - 1, "R1 strobe timing", n, CONV - 1);
      @(negedge clk);
      chk(st_sleep && !res_take, "R1 sleep after strobe", {st_sleep, res_take}, 2'b10);

      // R2/R3: long sleep with serial clock activity while deselected
      for (int k = 0; k < 40; k++) pulse_sclk();
      chk(st_sleep, "R2 sleep held", st_sleep, 1);
      chk(!sdo_oe && !sdo, "R3 deselected line", {sdo_oe, sdo}, 0);

      // R5/R6: full frame of pattern A, unaffected by the ignored clocks (R2)
      sel_n = 1'b0;
      repeat (4) @(negedge clk);
      chk(st_shift, "R2 output phase entered", st_shift, 1);
      push_frame(1'b1, 1'b0, 24'hA5C30F, 4'h9, 32, "R2 R5 R6 pattern A");
      read_bits(32);
      pulse_sclk();
      // R7: frame end restarts conversion and raises the flag
      chk(st_convert, "R7 converting after frame", st_convert, 1);
      chk(sdo_oe && sdo, "R7 flag high", {sdo_oe, sdo}, 2'b11);

      // R9/R4: select kept low, stub changes during conversion
      set_result(1'b0, 1'b1, 24'h3C5A96, 4'h6);
      @(negedge clk);
      chk(sdo === 1'b1, "R4 flag during conversion", sdo, 1);
      n = 0;
      while (sdo && n < 4 * CONV) begin
         @(negedge clk);
         n++;
      end
      chk(!sdo && sdo_oe, "R4 flag falls on completion", sdo, 0);
      repeat (3) @(negedge clk);
      push_frame(1'b0, 1'b1, 24'h3C5A96, 4'h6, 32, "R9 R5 pattern B");
      read_bits(32);
      pulse_sclk();
      chk(st_convert, "R7 second frame end", st_convert, 1);

      // R8: abort partway
      sel_n = 1'b1;
      set_result(1'b1, 1'b1, 24'hFFFFFF, 4'hF);
      wait_sleep();
      sel_n = 1'b0;
      repeat (4) @(negedge clk);
      push_frame(1'b1, 1'b1, 24'hFFFFFF, 4'hF, 5, "R8 partial pattern C");
      read_bits(5);
      sel_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(st_convert, "R8 abort to conversion", st_convert, 1);
      chk(!sdo_oe && !sdo, "R3 line off after abort", {sdo_oe, sdo}, 0);

      // R8: next frame carries the fresh result of the new conversion
      set_result(1'b0, 1'b0, 24'h000001, 4'h0);
      wait_sleep();
      chk(st_sleep, "R8 sleep after new conversion", st_sleep, 1);
      sel_n = 1'b0;
      repeat (4) @(negedge clk);
      push_frame(1'b0, 1'b0, 24'h000001, 4'h0, 32, "R8 R5 pattern D");
      read_bits(32);
      pulse_sclk();
      chk(st_convert, "R7 final frame end", st_convert, 1);
      sel_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0, "R5 all bits consumed", exp_q.size(), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule